// File: doc/BRIEF.md
# Station-Address PROM Window Decoder

This block sits behind a host bus port of a network controller and decodes accesses into a small register window. The low sixteen bytes of the window hold a byte-wide station-address store. Word and dword accesses above that range go out on a register-port interface with separate word and dword strobes. A second, memory-mapped aperture reaches the same resources and uses a single address bit to pick the store or the register port.

Which access sizes are legal on the store depends on a word/dword I/O mode input. Writes to the store are gated by a write-enable input. Multi-byte accesses are assembled little-endian, and each byte lane wraps its index modulo sixteen. A read that matches no legal case returns all ones across its width. Every read answers one clock after its strobe, together with a one-cycle valid pulse.

Top module: `stn_addr_window`

## Requirements
- R1: On the I/O aperture (`memAperture`=0), offsets 0..15 address the 16-byte store, with the byte index taken from `busAddr[3:0]`. Reads of the store are always allowed. Reset clears every byte of the store to zero.
- R2: A write to the store changes it only while `promWrEn` is 1. A write with `promWrEn` at 0 leaves every byte unchanged.
- R3: With `dwordMode`=0 on the I/O aperture, the store accepts 1-byte accesses at any offset and 2-byte accesses only at even offsets. A 4-byte access, or a 2-byte access at an odd offset, is unmatched.
- R4: With `dwordMode`=1 on the I/O aperture, the store accepts only 4-byte accesses at offsets whose two low bits are zero. Every other size or alignment is unmatched.
- R5: In a multi-byte store access, byte k of the access uses index (start+k) mod 16 and bus bits [8k+7:8k], so the lowest address sits in bits 7:0.
- R6: On the I/O aperture at offsets of 16 and above, a 2-byte access pulses `regWordStb` and a 4-byte access pulses `regDwordStb`, with `regAddr` equal to `busAddr` and `regWrite` equal to `busWr`, in the same cycle as the bus strobe. A 1-byte access raises neither strobe.
- R7: An unmatched read returns 0x000000FF for size 1, 0x0000FFFF for size 2 and 0xFFFFFFFF for any other size. An unmatched write changes nothing.
- R8: On the memory aperture (`memAperture`=1) with `busAddr[4]`=0, the store is reached at index `busAddr[3:0]` for sizes 1, 2 and 4, with no alignment check and no dependence on `dwordMode`.
- R9: On the memory aperture with `busAddr[4]`=1, 2-byte and 4-byte accesses pulse the word or dword strobe with `regAddr` = `busAddr[3:0]`, and 1-byte accesses are dropped (a read returns 0xFF).
- R10: `rdValid` pulses for exactly the clock after each read strobe, with `rdData` valid in that cycle. A register-port read returns `regRdata` as sampled in the strobe cycle, masked to the low 16 bits for a word access.
- R11: While `rstN` is low, both register-port strobes and `rdValid` stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAperture | input | 1 | 0 = I/O aperture, 1 = memory aperture |
| busAddr | input | 5 | Byte offset within the window |
| busSize | input | 3 | Access size in bytes (1, 2 or 4) |
| busWdata | input | 32 | Write data, little-endian lanes |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| dwordMode | input | 1 | Store accepts dword accesses only when set |
| promWrEn | input | 1 | Enables writes to the store |
| rdData | output | 32 | Read result, registered |
| rdValid | output | 1 | Pulses with each read result |
| regWordStb | output | 1 | Register-port 16-bit access strobe |
| regDwordStb | output | 1 | Register-port 32-bit access strobe |
| regWrite | output | 1 | Register-port access is a write |
| regAddr | output | 5 | Register-port offset |
| regWdata | output | 32 | Register-port write data |
| regRdata | input | 32 | Register-port read data, same cycle as strobe |

## Verification
The bound assertions check, on every cycle, the timing and the exclusivity of the port signals. The two register strobes are never high together, never rise for a byte access, and never rise outside the high half of the selected aperture. A memory-aperture register offset stays below sixteen. `rdValid` tracks the read strobe one cycle later, and a byte read above the store floats to 0xFF. The stored contents can only be shown by the bench's scenarios, which compare every access against a behavioural model of the store. These scenarios cover the write-enable gate, the alignment rules of each mode, little-endian assembly with index wrap, and the all-ones widths of unmatched reads.

// File: rtl/stn_addr_pkg.sv
package stn_addr_pkg;

  // Width selector used for read masking
  typedef enum logic [1:0] {
    WID_BYTE  = 2'd0,
    WID_WORD  = 2'd1,
    WID_DWORD = 2'd2
  } accWidth_e;

  // Strobes from decode control to the datapath
  typedef struct packed {
    logic      promRd;
    logic      promWr;
    logic      regRd;
    logic      floatRd;
    logic [2:0] nBytes;
    accWidth_e widthSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/stn_addr_ctrl.sv
module stn_addr_ctrl
  import stn_addr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PROM_BYTES = 16
) (
  input  logic              rstN,
  input  logic              memAperture,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dwordMode,
  input  logic              promWrEn,
  output ctrlStrobes_t      stb,
  output logic              regWordStb,
  output logic              regDwordStb,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr
);

  localparam int IDX_W = $clog2(PROM_BYTES);

  logic isByte, isWord, isDword, anySize;
  logic inHigh, promOk, regOk, accessOn;

  always_comb begin
    isByte  = (busSize == 3'd1);
    isWord  = (busSize == 3'd2);
    isDword = (busSize == 3'd4);
    anySize = isByte | isWord | isDword;

    if (memAperture) begin
      // one address bit chooses store or registers; no alignment rules
      inHigh = busAddr[IDX_W];
      promOk = !inHigh && anySize;
    end else begin
      inHigh = (busAddr >= ADDR_W'(PROM_BYTES));
      if (dwordMode)
        promOk = !inHigh && isDword && (busAddr[1:0] == 2'b00);
      else
        promOk = !inHigh && (isByte || (isWord && !busAddr[0]));
    end
    regOk = inHigh && (isWord || isDword);
  end

  assign accessOn = rstN && (busRd || busWr);

  always_comb begin
    stb          = '0;
    stb.promRd   = busRd && promOk;
    stb.promWr   = busWr && promOk && promWrEn;
    stb.regRd    = busRd && regOk;
    stb.floatRd  = busRd && !promOk && !regOk;
    stb.nBytes   = busSize;
    stb.widthSel = isByte ? WID_BYTE : (isWord ? WID_WORD : WID_DWORD);
    if (!rstN) stb = '0;
  end

  assign regWordStb  = accessOn && regOk && isWord;
  assign regDwordStb = accessOn && regOk && isDword;
  assign regWrite    = busWr;
  assign regAddr     = memAperture ? ADDR_W'(busAddr[IDX_W-1:0]) : busAddr;

endmodule

// File: rtl/stn_addr_dp.sv
module stn_addr_dp
  import stn_addr_pkg::*;
#(
  parameter int PROM_BYTES = 16,
  parameter int DATA_W     = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 stb,
  input  logic [$clog2(PROM_BYTES)-1:0] promIdx,
  input  logic [DATA_W-1:0]            busWdata,
  input  logic [DATA_W-1:0]            regRdata,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid
);

  localparam int IDX_W = $clog2(PROM_BYTES);
  localparam int LANES = DATA_W / 8;

  logic [7:0]       promMem [PROM_BYTES];
  logic [IDX_W-1:0] laneIdx [LANES];
  logic [LANES-1:0] laneOn;
  logic [DATA_W-1:0] assembled;
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] rdNext;

  // per-lane index with modulo wrap
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneIdx[g]      = promIdx + IDX_W'(g);
    assign laneOn[g]       = (32'(stb.nBytes) > g);
    assign assembled[8*g +: 8] = laneOn[g] ? promMem[laneIdx[g]] : 8'h00;
  end

  always_comb begin
    case (stb.widthSel)
      WID_BYTE: widthMask = DATA_W'(8'hFF);
      WID_WORD: widthMask = DATA_W'(16'hFFFF);
      default:  widthMask = '1;
    endcase
  end

  always_comb begin
    rdNext = rdData;
    if (stb.promRd)       rdNext = assembled & widthMask;
    else if (stb.regRd)   rdNext = regRdata & widthMask;
    else if (stb.floatRd) rdNext = widthMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PROM_BYTES; i++) promMem[i] <= 8'h00;
    end else if (stb.promWr) begin
      for (int k = 0; k < LANES; k++)
        if (laneOn[k]) promMem[laneIdx[k]] <= busWdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= rdNext;
      rdValid <= stb.promRd | stb.regRd | stb.floatRd;
    end
  end

endmodule

// File: rtl/stn_addr_window.sv
module stn_addr_window
  import stn_addr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PROM_BYTES = 16,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memAperture,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dwordMode,
  input  logic              promWrEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              regWordStb,
  output logic              regDwordStb,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int IDX_W = $clog2(PROM_BYTES);

  ctrlStrobes_t ctrlStb;

  stn_addr_ctrl #(.ADDR_W(ADDR_W), .PROM_BYTES(PROM_BYTES)) ctrlInst (
    .rstN        (rstN),
    .memAperture (memAperture),
    .busAddr     (busAddr),
    .busSize     (busSize),
    .busRd       (busRd),
    .busWr       (busWr),
    .dwordMode   (dwordMode),
    .promWrEn    (promWrEn),
    .stb         (ctrlStb),
    .regWordStb  (regWordStb),
    .regDwordStb (regDwordStb),
    .regWrite    (regWrite),
    .regAddr     (regAddr)
  );

  stn_addr_dp #(.PROM_BYTES(PROM_BYTES), .DATA_W(DATA_W)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctrlStb),
    .promIdx  (busAddr[IDX_W-1:0]),
    .busWdata (busWdata),
    .regRdata (regRdata),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign regWdata = busWdata;

endmodule

// File: rtl/stn_addr_window_chk.sv
module stn_addr_window_chk #(
  parameter int ADDR_W     = 5,
  parameter int PROM_BYTES = 16,
  parameter int DATA_W     = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memAperture,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busSize,
  input logic              busRd,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              regWordStb,
  input logic              regDwordStb,
  input logic [ADDR_W-1:0] regAddr
);

  localparam int IDX_W = $clog2(PROM_BYTES);

  // R6: never both register strobes at once
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWordStb, regDwordStb}));

  // R6, R9: byte accesses never reach the register port
  a_r6_byte_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busSize == 3'd1) |-> !(regWordStb || regDwordStb));

  // R6, R9: strobes only in the high half of the selected aperture
  a_r6_strobe_range: assert property (@(posedge clk) disable iff (!rstN)
    (regWordStb || regDwordStb) |->
      (memAperture ? busAddr[IDX_W] : (busAddr >= ADDR_W'(PROM_BYTES))));

  // R9: memory-aperture register offsets fold into the low bits
  a_r9_mmio_offset: assert property (@(posedge clk) disable iff (!rstN)
    (memAperture && (regWordStb || regDwordStb)) |-> (regAddr < ADDR_W'(PROM_BYTES)));

  // R10: each read answers exactly one clock later
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);

  a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> !rdValid);

  // R7: byte read above the store floats to 0xFF
  a_r7_byte_float: assert property (@(posedge clk) disable iff (!rstN)
    (!memAperture && busRd && busSize == 3'd1 && busAddr >= ADDR_W'(PROM_BYTES))
      |=> (rdData == DATA_W'(8'hFF)));

  // R11: quiet port while in reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rstN |-> !(regWordStb || regDwordStb));

endmodule

bind stn_addr_window stn_addr_window_chk #(
  .ADDR_W(ADDR_W), .PROM_BYTES(PROM_BYTES), .DATA_W(DATA_W)
) chkInst (.*);

// File: tb/stn_addr_window_test.sv
`timescale 1ns/1ps
module stn_addr_window_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        memAperture;
  logic [4:0]  busAddr;
  logic [2:0]  busSize;
  logic [31:0] busWdata;
  logic        busRd, busWr;
  logic        dwordMode, promWrEn;
  logic [31:0] rdData;
  logic        rdValid;
  logic        regWordStb, regDwordStb, regWrite;
  logic [4:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int promModel [16];

  always #4 clk = ~clk;

  stn_addr_window uut (
    .clk(clk), .rstN(rstN), .memAperture(memAperture), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRd(busRd), .busWr(busWr),
    .dwordMode(dwordMode), .promWrEn(promWrEn), .rdData(rdData),
    .rdValid(rdValid), .regWordStb(regWordStb), .regDwordStb(regDwordStb),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one access, checked against the behavioural model
  task automatic access(string tag, bit ap, int addr, int size, bit rd, bit wr,
                        logic [31:0] wd);
    bit promHit, regHit;
    logic [31:0] expRd, mask;
    @(negedge clk);
    check(tag, "idle rdValid", {31'b0, rdValid}, 32'd0);
    memAperture = ap; busAddr = addr[4:0]; busSize = size[2:0];
    busWdata = wd; busRd = rd; busWr = wr;
    promHit = 0; regHit = 0;
    if (!ap) begin
      if (addr < 16)
        promHit = dwordMode ? (size == 4 && addr % 4 == 0)
                            : (size == 1 || (size == 2 && addr % 2 == 0));
      else
        regHit = (size == 2 || size == 4);
    end else begin
      if (addr < 16) promHit = (size == 1 || size == 2 || size == 4);
      else           regHit  = (size == 2 || size == 4);
    end
    mask = (size == 1) ? 32'hFF : (size == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (promHit) begin
      expRd = 0;
      for (int k = 0; k < size; k++)
        expRd = expRd | (32'(promModel[(addr + k) % 16]) << (8 * k));
    end else if (regHit) expRd = regRdata & mask;
    else expRd = mask;
    #1;
    check(tag, "word strobe", {31'b0, regWordStb}, {31'b0, regHit && size == 2});
    check(tag, "dword strobe", {31'b0, regDwordStb}, {31'b0, regHit && size == 4});
    if (regHit) begin
      check(tag, "reg addr", {27'b0, regAddr}, ap ? 32'(addr % 16) : 32'(addr));
      check(tag, "reg write", {31'b0, regWrite}, {31'b0, wr});
    end
    @(negedge clk);
    check(tag, "rdValid", {31'b0, rdValid}, {31'b0, rd});
    if (rd) check(tag, "rdData", rdData, expRd);
    if (wr && promHit && promWrEn)
      for (int k = 0; k < size; k++)
        promModel[(addr + k) % 16] = int'((wd >> (8 * k)) & 32'hFF);
    busRd = 0; busWr = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) promModel[i] = 0;
    rstN = 0; memAperture = 0; busAddr = 5'd16; busSize = 3'd2;
    busWdata = 0; busRd = 0; busWr = 1; dwordMode = 0; promWrEn = 0;
    regRdata = 32'hC0DE_5A17;
    repeat (3) @(negedge clk);
    // R11: strobes quiet in reset despite a legal register write
    check("R11", "reset word strobe", {31'b0, regWordStb}, 32'd0);
    check("R11", "reset rdValid", {31'b0, rdValid}, 32'd0);
    busWr = 0;
    @(negedge clk);
    rstN = 1;

    // R1: store cleared by reset
    for (int a = 0; a < 16; a++) access("R1", 0, a, 1, 1, 0, 0);
    // R2: writes ignored with enable low
    access("R2", 0, 3, 1, 0, 1, 32'h5D);
    access("R2", 0, 3, 1, 1, 0, 0);
    promWrEn = 1;
    for (int a = 0; a < 16; a++) access("R1", 0, a, 1, 0, 1, 32'(8'h10 + 8'(a * 7)));
    for (int a = 0; a < 16; a++) access("R1", 0, a, 1, 1, 0, 0);
    // R3: word mode rules
    access("R3", 0, 4, 2, 1, 0, 0);
    access("R3", 0, 5, 2, 1, 0, 0);
    access("R3", 0, 5, 2, 0, 1, 32'hBEEF);
    access("R3", 0, 4, 4, 1, 0, 0);
    access("R3", 0, 6, 2, 0, 1, 32'h9A8B);
    access("R5", 0, 6, 2, 1, 0, 0);
    // R4: dword mode rules
    dwordMode = 1;
    access("R4", 0, 8, 4, 1, 0, 0);
    access("R4", 0, 2, 4, 1, 0, 0);
    access("R4", 0, 2, 2, 1, 0, 0);
    access("R4", 0, 1, 1, 1, 0, 0);
    access("R4", 0, 1, 1, 0, 1, 32'h77);
    access("R5", 0, 12, 4, 0, 1, 32'h4433_2211);
    access("R5", 0, 12, 4, 1, 0, 0);
    access("R4", 0, 12, 1, 1, 0, 0);
    // R8: memory aperture ignores mode and alignment; R5 wrap
    access("R8", 1, 14, 4, 1, 0, 0);
    access("R8", 1, 15, 2, 0, 1, 32'hE1F0);
    access("R5", 1, 13, 4, 1, 0, 0);
    access("R8", 1, 1, 1, 1, 0, 0);
    dwordMode = 0;
    access("R8", 1, 3, 4, 1, 0, 0);
    // R6, R10: register port on I/O aperture
    access("R6", 0, 16, 2, 1, 0, 0);
    access("R6", 0, 20, 4, 1, 0, 0);
    access("R6", 0, 22, 2, 0, 1, 32'h1234);
    access("R6", 0, 17, 1, 1, 0, 0);
    regRdata = 32'h8765_F00D;
    access("R10", 0, 28, 4, 1, 0, 0);
    access("R10", 0, 18, 2, 1, 0, 0);
    // R9: memory aperture register half
    access("R9", 1, 18, 2, 1, 0, 0);
    access("R9", 1, 30, 4, 0, 1, 32'hCAFE_0001);
    access("R9", 1, 21, 1, 1, 0, 0);
    // R7: odd sizes float to full width, writes do nothing
    access("R7", 0, 0, 3, 1, 0, 0);
    access("R7", 0, 0, 3, 0, 1, 32'hFFFF_FFFF);
    access("R7", 1, 16, 3, 1, 0, 0);
    access("R7", 0, 0, 2, 1, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule